// File: doc/BRIEF.md
# UART Receive Buffer and Line Status

This block sits behind a UART receive shift register. Each completed character arrives on a one-cycle valid strobe. The block stores it in a small first-in first-out buffer. Software drains the buffer with buffer-read strobes and polls a read-only 8-bit line status byte.

The status byte has two live flags. The data-ready flag shows that at least one unread character is waiting. The overrun flag records that a character arrived while the buffer was full and had to be thrown away. The overrun flag stays set until software reads the status byte. A character that cannot be stored is dropped, and the stored characters are never overwritten. Parity, framing, break and transmitter status are not part of this block.

Top module: `uart_rx_line_status`

## Requirements
- R1: After reset, `status_o` is 0x00 and `buf_data_o` is 0x00.
- R2: Status bit 0 (data ready) is 1 whenever the buffer holds one or more unread characters, and 0 only when the buffer is empty. It follows the buffer state in the cycle after the strobe that changes it.
- R3: The buffer holds DEPTH (16) characters of 8 bits in arrival order. A buffer-read strobe on a non-empty buffer pops the oldest entry, and that entry appears on `buf_data_o` in the cycle after the strobe.
- R4: Status bit 1 (overrun) is 1 in the cycle after a character strobe that arrives while the buffer is full and no buffer read is made in the same cycle.
- R5: On an overrun, the buffer contents and their order are left intact, and the arriving character is discarded.
- R6: A status-read strobe clears the overrun bit in the next cycle. Without a status read, the overrun bit stays set.
- R7: If a status read and a new overrun occur in the same cycle, the overrun bit is 1 afterwards.
- R8: A buffer read and a character arrival in the same cycle on a full buffer do not cause an overrun. The head is popped and the new character is stored.
- R9: A buffer-read strobe on an empty buffer leaves `buf_data_o` holding the last popped value and leaves the buffer and the status byte unchanged.
- R10: Status bits 7 to 2 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| char_valid_i | input | 1 | Strobe: an assembled character is present on `char_data_i` |
| char_data_i | input | 8 | Assembled receive character |
| buf_read_i | input | 1 | Strobe: read the receive buffer (pops the head) |
| stat_read_i | input | 1 | Strobe: read the line status byte (clears overrun) |
| buf_data_o | output | 8 | Last character popped from the buffer |
| status_o | output | 8 | Line status byte: bit 0 data ready, bit 1 overrun |

## Verification
The bench fills the buffer one character at a time, at every level from empty to full. At each level it checks data ready, which separates "one entry" from "empty". It then overruns the full buffer with and without a same-cycle status read. Drained data exposes any overwrite or ordering fault, and the flag timing separates a set from a clear. Reads on an empty buffer show whether the held output or the buffer state is disturbed. A same-cycle read and write on a full buffer separates a real overrun from a balanced one. A long pseudo-random mix of all three strobes is compared each cycle against an arithmetic model of the buffer.

// File: rtl/uart_rx_ls_pkg.sv
package uart_rx_ls_pkg;
  localparam int unsigned STAT_W    = 8;
  localparam int unsigned STAT_DR_B = 0;
  localparam int unsigned STAT_OE_B = 1;
endpackage

// File: rtl/rx_char_fifo.sv
module rx_char_fifo #(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          rd_en_i,
  output logic [DW-1:0] head_o,
  output logic [CW-1:0] count_o,
  output logic          full_o,
  output logic          empty_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [PW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] count_q;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[wr_ptr_q] <= wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (wr_en_i) wr_ptr_q <= nxt(wr_ptr_q);
      if (rd_en_i) rd_ptr_q <= nxt(rd_ptr_q);
      case ({wr_en_i, rd_en_i})
        2'b10:   count_q <= count_q + CW'(1);
        2'b01:   count_q <= count_q - CW'(1);
        default: count_q <= count_q;
      endcase
    end
  end

  assign head_o  = mem_q[rd_ptr_q];
  assign count_o = count_q;
  assign full_o  = (count_q == CW'(DEPTH));
  assign empty_o = (count_q == '0);

  // R5
  no_overwrite_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |-> (!full_o || rd_en_i));
  // R9
  no_underflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i |-> !empty_o);
endmodule

// File: rtl/rx_line_status.sv
module rx_line_status
  import uart_rx_ls_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ovr_event_i,
  input  logic              stat_read_i,
  input  logic              not_empty_i,
  output logic [STAT_W-1:0] status_o
);
  logic ovr_q;

  // a new event wins over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          ovr_q <= 1'b0;
    else if (ovr_event_i) ovr_q <= 1'b1;
    else if (stat_read_i) ovr_q <= 1'b0;
  end

  always_comb begin
    status_o            = '0;
    status_o[STAT_DR_B] = not_empty_i;
    status_o[STAT_OE_B] = ovr_q;
  end

  // R6
  ovr_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[STAT_OE_B] && !stat_read_i |=> status_o[STAT_OE_B]);
  // R7
  ovr_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_event_i && stat_read_i |=> status_o[STAT_OE_B]);
endmodule

// File: rtl/uart_rx_line_status.sv
module uart_rx_line_status
  import uart_rx_ls_pkg::*;
#(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              char_valid_i,
  input  logic [DW-1:0]     char_data_i,
  input  logic              buf_read_i,
  input  logic              stat_read_i,
  output logic [DW-1:0]     buf_data_o,
  output logic [STAT_W-1:0] status_o
);
  logic [DW-1:0] head;
  logic [CW-1:0] count;
  logic          full, empty, pop, push, ovr_event;
  logic [DW-1:0] rd_data_q;

  assign pop       = buf_read_i && !empty;
  assign ovr_event = char_valid_i && full && !buf_read_i;
  assign push      = char_valid_i && !ovr_event;

  rx_char_fifo #(.DW(DW), .DEPTH(DEPTH)) i_fifo (
    .clk_i, .rst_ni,
    .wr_en_i(push), .wr_data_i(char_data_i), .rd_en_i(pop),
    .head_o(head), .count_o(count), .full_o(full), .empty_o(empty)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  rd_data_q <= '0;
    else if (pop) rd_data_q <= head;
  end
  assign buf_data_o = rd_data_q;

  rx_line_status i_stat (
    .clk_i, .rst_ni,
    .ovr_event_i(ovr_event), .stat_read_i(stat_read_i),
    .not_empty_i(!empty), .status_o(status_o)
  );

  // R4
  ovr_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    char_valid_i && full && !buf_read_i |=> status_o[STAT_OE_B]);
  // R5
  ovr_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    char_valid_i && full && !buf_read_i |=> $stable(count));
  // R2
  dr_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    char_valid_i |=> status_o[STAT_DR_B]);
  // R8
  full_rw_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    char_valid_i && full && buf_read_i && !status_o[STAT_OE_B] |=> !status_o[STAT_OE_B] && full);
  // R9
  empty_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_read_i && empty |=> $stable(buf_data_o));
endmodule

// File: tb/test_uart_rx_line_status.sv
module test_uart_rx_line_status;
  localparam int DEPTH = 16;
  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic char_valid_i = 1'b0, buf_read_i = 1'b0, stat_read_i = 1'b0;
  logic [7:0] char_data_i = '0;
  logic [7:0] buf_data_o, status_o;
  int checks = 0, failures = 0;
  bit done = 0;

  logic [7:0] mq[$];
  logic       m_ovr = 0;
  logic [7:0] m_last = 0;

  always #10 clk_i = ~clk_i;

  uart_rx_line_status i_uart_rx_line_status (
    .clk_i, .rst_ni, .char_valid_i, .char_data_i, .buf_read_i, .stat_read_i,
    .buf_data_o, .status_o
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic compare(input string tag_ovr, input string tag_dat);
    chk("R2", int'(status_o[0]), int'(mq.size() != 0));
    chk(tag_ovr, int'(status_o[1]), int'(m_ovr));
    chk("R10", int'(status_o[7:2]), 0);
    chk(tag_dat, int'(buf_data_o), int'(m_last));
  endtask

  task automatic tick(input bit cv, input logic [7:0] d, input bit br, input bit sr,
                      input string tag_ovr, input string tag_dat);
    bit full, set;
    char_valid_i = cv; char_data_i = d; buf_read_i = br; stat_read_i = sr;
    full = (mq.size() == DEPTH);
    set  = cv && full && !br;
    if (br && mq.size() > 0) m_last = mq.pop_front();
    if (cv && !set) mq.push_back(d);
    m_ovr = set ? 1'b1 : (sr ? 1'b0 : m_ovr);
    @(posedge clk_i);
    #5;
    char_valid_i = 0; buf_read_i = 0; stat_read_i = 0;
    compare(tag_ovr, tag_dat);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr = 16'hACE1;
    #25;
    // R1
    chk("R1", int'(status_o), 0);
    chk("R1", int'(buf_data_o), 0);
    rst_ni = 1'b1;
    #10;
    // R9: read on empty right after reset
    tick(0, 0, 1, 0, "R9", "R9");
    // R2 R3: fill to full, data-ready at each level
    for (int i = 0; i < DEPTH; i++) tick(1, 8'(i * 7 + 3), 0, 0, "R4", "R3");
    // R4 R5: overrun on full
    tick(1, 8'hEE, 0, 0, "R4", "R5");
    // R6: sticky then clear
    tick(0, 0, 0, 0, "R6", "R6");
    tick(0, 0, 0, 1, "R6", "R6");
    // R7: overrun and status read together
    tick(1, 8'hDD, 0, 1, "R7", "R5");
    tick(0, 0, 0, 1, "R6", "R6");
    // R8: balanced read/write on full
    for (int i = 0; i < 4; i++) tick(1, 8'(8'h80 + i), 1, 0, "R8", "R8");
    // R3 R5: drain, order intact
    for (int i = 0; i < DEPTH; i++) tick(0, 0, 1, 0, "R6", "R3");
    // R9: empty reads hold last value
    for (int i = 0; i < 3; i++) tick(0, 0, 1, 0, "R9", "R9");
    // random mix
    for (int i = 0; i < 2000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      tick(lfsr[0] | lfsr[5], lfsr[15:8], lfsr[1] & lfsr[6], lfsr[2] & lfsr[3] & lfsr[4],
           "R4", "R3");
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule